// File: doc/BRIEF.md
# Period-Limited Fixed-Width Pulse Generator

This block turns trigger events into output pulses of a fixed length in clock cycles and enforces a minimum spacing between the starts of successive pulses. Trigger events arrive as one-cycle pulses that mark the rising edge of an already filtered and synchronised trigger. The raw trigger level and a one-cycle falling-edge pulse come in alongside. The block is used per channel in a pulse-repeater path. A trigger that comes too soon after the previous accepted one is dropped, and that drop is reported on a one-cycle error strobe.

The spacing is set as a period in clock cycles, so any ratio of width to period may be chosen, including ratios that are not whole fractions. Typical settings are width 24 with period 191 and width 5 with period 9. A much longer period, such as 4800, serves as a rate cap for continuous operation. A generate-time check rejects a width outside 2 to 40 and any period that is not larger than the width. All pins are plain control and status signals. The block has no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `period_pulse_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pulse_o` and `err_o` are low after that edge. The first rising-edge trigger after reset is accepted.
- R2: A rising-edge trigger that is seen at an edge with `enable` high and no period running is accepted. `pulse_o` goes high right after that same edge.
- R3: An accepted pulse stays high for exactly WIDTH clock cycles and then goes low.
- R4: A rising-edge trigger seen PERIOD or more edges after the edge that accepted the previous trigger is accepted.
- R5: A rising-edge trigger seen 1 to PERIOD-1 edges after the accepting edge is rejected. It starts no pulse, and `err_o` is high for exactly the one cycle after that edge.
- R6: A rejected trigger neither restarts nor extends the running period. A trigger PERIOD edges after the last accepted one is still accepted.
- R7: While `enable` is low, rising-edge triggers start no pulse and raise no error. A pulse already running finishes normally, and an idle block stays idle.
- R8: Only the rising-edge pulse input starts a pulse. A held-high trigger level or a falling-edge pulse never starts one, even after the period expires. The two edge pulses are never high together, and a rising-edge pulse comes only with the level high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Accept triggers when high |
| trig_level | input | 1 | Filtered trigger level |
| trig_rise_p | input | 1 | One-cycle pulse on trigger rising edge |
| trig_fall_p | input | 1 | One-cycle pulse on trigger falling edge |
| pulse_o | output | 1 | Fixed-width output pulse |
| err_o | output | 1 | One-cycle strobe for a rejected trigger |

## Verification
The assertions check on every cycle that an accepted trigger is followed by a pulse on the next cycle. They also check that an early trigger is followed by the error strobe, that no pulse starts while a period runs, that the strobe stays low while the block is disabled, and that the edge inputs are consistent. The exact pulse length, the acceptance boundary at PERIOD edges, and the rule that a rejected trigger leaves the period unchanged depend on the distance between events. Only the bench's sweeps over trigger spacing and rejection position show these, using a small width-3, period-7 configuration.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  // Bits needed to hold values 0..max_val.
  function automatic int cnt_bits(input int max_val);
    int b;
    b = 1;
    while ((1 << b) <= max_val) b++;
    return b;
  endfunction
endpackage

// File: rtl/ppg_downcnt.sv
module ppg_downcnt #(
  parameter int BITS     = 8,
  parameter int LOAD_VAL = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic at_zero
);
  logic [BITS-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= BITS'(LOAD_VAL);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/ppg_ctrl.sv
module ppg_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic trig_level,
  input  logic trig_rise_p,
  input  logic trig_fall_p,
  input  logic period_done,
  input  logic width_done,
  output logic start,
  output logic pulse_o,
  output logic err_o
);
  logic reject;

  assign start  = enable && trig_rise_p && period_done;
  assign reject = enable && trig_rise_p && !period_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      err_o <= reject;
      if (start)           pulse_o <= 1'b1;
      else if (width_done) pulse_o <= 1'b0;
    end
  end

  AST_START_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && trig_rise_p && period_done) |=> pulse_o); // R2
  AST_ERR_ON_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && trig_rise_p && !period_done) |=> err_o); // R5
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !err_o); // R7
  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(trig_rise_p && trig_fall_p)); // R8
  AST_RISE_WITH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rise_p |-> trig_level); // R8
endmodule

// File: rtl/period_pulse_gen.sv
module period_pulse_gen #(
  parameter int WIDTH  = 24,
  parameter int PERIOD = 191
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic trig_level,
  input  logic trig_rise_p,
  input  logic trig_fall_p,
  output logic pulse_o,
  output logic err_o
);
  localparam int CBITS = ppg_pkg::cnt_bits(PERIOD - 1);

  if (WIDTH < 2 || WIDTH > 40 || PERIOD <= WIDTH) begin : g_bad_cfg
    $error("period_pulse_gen: need 2 <= WIDTH <= 40 and PERIOD > WIDTH");
  end

  logic       start;
  logic [1:0] done;   // [0] width counter, [1] period counter

  for (genvar i = 0; i < 2; i++) begin : g_cnt
    localparam int LOADV = (i == 0) ? WIDTH - 1 : PERIOD - 1;
    ppg_downcnt #(.BITS(CBITS), .LOAD_VAL(LOADV)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (start),
      .at_zero (done[i])
    );
  end

  ppg_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .trig_level  (trig_level),
    .trig_rise_p (trig_rise_p),
    .trig_fall_p (trig_fall_p),
    .period_done (done[1]),
    .width_done  (done[0]),
    .start       (start),
    .pulse_o     (pulse_o),
    .err_o       (err_o)
  );

  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !done[1] |=> !$rose(pulse_o)); // R4
  AST_ERR_NOT_START: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_o && $rose(pulse_o))); // R5
endmodule

// File: tb/period_pulse_gen_bench.sv
module period_pulse_gen_bench;
  localparam int W = 3;
  localparam int P = 7;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, en = 1'b0, lvl = 1'b0, rise = 1'b0, fall = 1'b0;
  logic pulse, err;

  int n_chk = 0, n_bad = 0;
  int e_idx = 0, last_acc = 0;
  bit has_acc = 0, done = 0;

  period_pulse_gen #(.WIDTH(W), .PERIOD(P)) u_period_pulse_gen (
    .clk(clk), .rst_n(rst_n), .enable(en), .trig_level(lvl),
    .trig_rise_p(rise), .trig_fall_p(fall), .pulse_o(pulse), .err_o(err));

  task automatic check(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at edge %0d: actual %b expected %b", req, what, e_idx, act, exp);
    end
  endtask

  // One cycle: drive at negedge, let the edge pass, check at next negedge.
  task automatic tick(bit t_en, bit t_rise, bit t_fall, bit t_lvl, string req);
    bit acc, rej, exp_p;
    en = t_en; rise = t_rise; fall = t_fall; lvl = t_lvl | t_rise;
    e_idx++;
    acc = t_en && t_rise && (!has_acc || (e_idx - last_acc) >= P);
    rej = t_en && t_rise && !acc;
    if (acc) begin has_acc = 1; last_acc = e_idx; end
    @(posedge clk);
    @(negedge clk);
    exp_p = has_acc && ((e_idx - last_acc) < W);
    check(req, "pulse_o", pulse, exp_p);
    check(req, "err_o", err, rej);
  endtask

  task automatic idle(int n, string req);
    for (int k = 0; k < n; k++) tick(1, 0, 0, 0, req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; en = 0; rise = 0; fall = 0; lvl = 0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      e_idx++;
      check("R1", "pulse_o in reset", pulse, 1'b0);
      check("R1", "err_o in reset", err, 1'b0);
    end
    has_acc = 0;
    rst_n = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1: first trigger after reset accepted; R2/R3 single pulse
    tick(1, 1, 0, 1, "R1");
    idle(P + 2, "R3");
    // R2 again with level held, then falling edge
    tick(1, 1, 0, 1, "R2");
    tick(1, 0, 0, 1, "R2");
    tick(1, 0, 1, 0, "R8");
    idle(P + 2, "R3");
    // R4/R5: sweep spacing between two triggers
    for (int d = 1; d <= P + 2; d++) begin
      tick(1, 1, 0, 1, "R4");
      idle(d - 1, "R5");
      tick(1, 1, 0, 1, (d >= P) ? "R4" : "R5");
      idle(P + 2, "R3");
    end
    // R6: a rejected trigger at every position, then one at exactly P
    for (int r = 1; r < P; r++) begin
      tick(1, 1, 0, 1, "R6");
      idle(r - 1, "R6");
      tick(1, 1, 0, 1, "R6");
      idle(P - r - 1, "R6");
      tick(1, 1, 0, 1, "R6");
      idle(P + 2, "R6");
    end
    // R7: disabled triggers, idle and during a pulse
    tick(0, 1, 0, 1, "R7");
    tick(0, 0, 0, 0, "R7");
    tick(1, 1, 0, 1, "R7");
    tick(0, 1, 0, 1, "R7");
    tick(0, 0, 0, 0, "R7");
    idle(P + 2, "R7");
    tick(1, 1, 0, 1, "R7");
    idle(P + 2, "R7");
    // R8: level held high across expiry, falling pulses, no rising pulse
    tick(1, 1, 0, 1, "R8");
    tick(1, 1, 0, 1, "R8");
    for (int k = 0; k < 2 * P; k++) tick(1, 0, 0, 1, "R8");
    tick(1, 0, 1, 0, "R8");
    idle(2, "R8");
    tick(1, 0, 1, 0, "R8");
    idle(2, "R8");
    // R1: reset in the middle of a pulse and a period
    tick(1, 1, 0, 1, "R1");
    tick(1, 0, 0, 0, "R1");
    do_reset();
    tick(1, 1, 0, 1, "R1");
    idle(P + 2, "R1");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule